// File: doc/BRIEF.md
# Continued-fraction rational approximator

This block finds a small fraction that stands in for a wider ratio. A caller presents a target ratio as an unsigned numerator and denominator, together with an upper limit for each part of the answer. The engine then expands the ratio as a continued fraction. Each partial quotient comes from an internal restoring divider. After each division, one multiply-accumulate step advances the numerator and denominator convergents.

The search ends in one of two ways. If the newest convergent breaks either limit, the engine falls back to the convergent before it. If the expansion runs out (the remaining divisor is zero), the engine keeps the newest convergent, which is then the exact ratio in lowest terms. A typical use is to derive the multiplier and divider of a fractional clock divider, with both limits set to 0xFFFF.

Top module: `cfrac_approx`

## Requirements
- R1: After reset, done is 0 and both result outputs are 0.
- R2: When the engine is idle and start is seen with a given denominator of zero, done pulses on the next cycle with result numerator 1 and result denominator 0, whatever the other inputs are.
- R3: At each check, if the current numerator is above the numerator limit or the current denominator is above the denominator limit, the engine stops and returns the previous convergent. This test comes before the zero-divisor test.
- R4: At each check that passes the limit test, if the remaining divisor is zero, the engine stops and returns the current convergent.
- R5: The convergents start as previous/current numerator 0/1 and previous/current denominator 1/0. Each step divides n by d to get quotient a and remainder r, then sets n to d and d to r. The new current value is previous + a × current, and the old current value becomes the previous one. A new value that does not fit in WIDTH bits is replaced by all ones.
- R6: done is high for exactly one cycle. For an accepted start with a nonzero denominator, done rises 1 + k·(WIDTH+2) cycles after the start edge, where k is the number of division steps taken.
- R7: A start that arrives while the engine is busy has no effect: the running search finishes with the result and timing of its own inputs.
- R8: The result outputs change only in the cycle that done is high, and hold their value between completions.
- R9: Each division yields a remainder smaller than its divisor, in WIDTH cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search; sampled only when idle |
| givenNum | input | WIDTH | Numerator of the target ratio |
| givenDen | input | WIDTH | Denominator of the target ratio |
| maxNum | input | WIDTH | Largest permitted result numerator |
| maxDen | input | WIDTH | Largest permitted result denominator |
| done | output | 1 | One-cycle completion pulse |
| bestNum | output | WIDTH | Result numerator |
| bestDen | output | WIDTH | Result denominator |

## Verification
The two stopping rules can both apply at the same check. The bench forces this with a target of 100/1 and a numerator limit of 50. There, the first quotient drives the numerator over its limit in the same step that empties the divisor. The result must be the rolled-back 1/0, not the exact 100/1. A second overlap, a new start in the done cycle, is judged by the behavioural model. That model accepts the start only when it is idle, and it is compared against the design on every clock.

// File: rtl/cfrac_pkg.sv
package cfrac_pkg;

  typedef struct packed {
    logic initRegs;
    logic unitResult;
    logic divGo;
    logic applyStep;
    logic takeCurrent;
    logic takePrevious;
  } ctrlStrobe_t;

  typedef struct packed {
    logic denInZero;
    logic overLimit;
    logic divisorZero;
    logic divLast;
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_DIVIDE = 2'd2,
    ST_UPDATE = 2'd3
  } engState_t;

endpackage

// File: rtl/cfrac_divider.sv
module cfrac_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             lastStep
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0] remR, quoR, dvsR;
  logic [CNT_W-1:0] cntR;
  logic             busyR;
  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   trial;
  logic             fits;

  // Trial subtraction of the divisor from the partial remainder with the next dividend bit
  assign shifted  = {remR, quoR[WIDTH-1]};
  assign fits     = shifted >= {1'b0, dvsR};
  assign trial    = shifted - {1'b0, dvsR};
  assign lastStep = busyR && (cntR == LAST_CNT);
  assign quotient  = quoR;
  assign remainder = remR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remR  <= '0;
      quoR  <= '0;
      dvsR  <= '0;
      cntR  <= '0;
      busyR <= 1'b0;
    end else if (go) begin
      remR  <= '0;
      quoR  <= dividend;
      dvsR  <= divisor;
      cntR  <= '0;
      busyR <= 1'b1;
    end else if (busyR) begin
      if (fits) begin
        remR <= trial[WIDTH-1:0];
        quoR <= {quoR[WIDTH-2:0], 1'b1};
      end else begin
        remR <= shifted[WIDTH-1:0];
        quoR <= {quoR[WIDTH-2:0], 1'b0};
      end
      cntR <= cntR + 1'b1;
      if (lastStep) busyR <= 1'b0;
    end
  end

  // R9: the divider goes quiet right after its final step
  assert_div_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lastStep |=> !busyR);

endmodule

// File: rtl/cfrac_datapath.sv
module cfrac_datapath import cfrac_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] givenNum,
  input  logic [WIDTH-1:0] givenDen,
  input  logic [WIDTH-1:0] maxNum,
  input  logic [WIDTH-1:0] maxDen,
  output dpStatus_t        status,
  output logic [WIDTH-1:0] bestNum,
  output logic [WIDTH-1:0] bestDen
);
  localparam int LANES = 2;
  localparam int WIDE  = 2 * WIDTH + 1;

  logic [WIDTH-1:0] nR, dR;
  logic [WIDTH-1:0] quotient, remainder;
  logic             divLast;

  logic [LANES-1:0][WIDTH-1:0] laneMax;
  logic [LANES-1:0][WIDTH-1:0] lanePrev, laneCur, laneLim, laneBest;
  logic [LANES-1:0]            laneOver;

  assign laneMax[0] = maxNum;
  assign laneMax[1] = maxDen;

  function automatic logic [WIDTH-1:0] macSat(input logic [WIDTH-1:0] prev,
                                               input logic [WIDTH-1:0] mult,
                                               input logic [WIDTH-1:0] cur);
    logic [WIDE-1:0] full;
    full = WIDE'(prev) + WIDE'(mult) * WIDE'(cur);
    if (|full[WIDE-1:WIDTH]) return '1;
    return full[WIDTH-1:0];
  endfunction

  cfrac_divider #(.WIDTH(WIDTH)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (strobe.divGo),
    .dividend (nR),
    .divisor  (dR),
    .quotient (quotient),
    .remainder(remainder),
    .lastStep (divLast)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nR <= '0;
      dR <= '0;
    end else if (strobe.initRegs) begin
      nR <= givenNum;
      dR <= givenDen;
    end else if (strobe.applyStep) begin
      nR <= dR;
      dR <= remainder;
    end
  end

  // Lane 0 carries numerator convergents, lane 1 denominator convergents
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    localparam logic [WIDTH-1:0] INIT_PREV = (lane == 0) ? '0 : WIDTH'(1);
    localparam logic [WIDTH-1:0] INIT_CUR  = (lane == 0) ? WIDTH'(1) : '0;

    logic [WIDTH-1:0] prevR, curR, limR, bestR;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prevR <= '0;
        curR  <= '0;
        limR  <= '0;
        bestR <= '0;
      end else begin
        if (strobe.initRegs) begin
          prevR <= INIT_PREV;
          curR  <= INIT_CUR;
          limR  <= laneMax[lane];
        end else if (strobe.applyStep) begin
          prevR <= curR;
          curR  <= macSat(prevR, quotient, curR);
        end
        if (strobe.takeCurrent)       bestR <= curR;
        else if (strobe.takePrevious) bestR <= prevR;
        else if (strobe.unitResult)   bestR <= INIT_CUR;
      end
    end

    assign lanePrev[lane] = prevR;
    assign laneCur[lane]  = curR;
    assign laneLim[lane]  = limR;
    assign laneBest[lane] = bestR;
    assign laneOver[lane] = curR > limR;
  end

  assign status.denInZero   = (givenDen == '0);
  assign status.overLimit   = |laneOver;
  assign status.divisorZero = (dR == '0);
  assign status.divLast     = divLast;

  assign bestNum = laneBest[0];
  assign bestDen = laneBest[1];

  // R9: every quotient step hands over a remainder below the divisor in use
  assert_rem_below_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.applyStep |-> (remainder < dR));

  // R3: a rolled-back result always lies inside both limits
  assert_rollback_in_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takePrevious |=> (laneBest[0] <= laneLim[0]) && (laneBest[1] <= laneLim[1]));

  // R4: an exhausted expansion returns the pair that passed the limit test
  assert_exact_within_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeCurrent |=> (laneBest[0] == $past(laneCur[0])) && (laneBest[1] <= laneLim[1]));

  // R5: convergents shift by one place on every step
  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.applyStep |=> (lanePrev[0] == $past(laneCur[0])) && (lanePrev[1] == $past(laneCur[1])));

endmodule

// File: rtl/cfrac_ctrl.sv
module cfrac_ctrl import cfrac_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output engState_t   engState,
  output logic        done
);
  engState_t stateR, stateNext;
  logic      doneR, finish;

  always_comb begin
    strobe    = '0;
    stateNext = stateR;
    unique case (stateR)
      ST_IDLE: begin
        if (start) begin
          strobe.initRegs = 1'b1;
          if (status.denInZero) strobe.unitResult = 1'b1;
          else                  stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.overLimit) begin
          strobe.takePrevious = 1'b1;
          stateNext = ST_IDLE;
        end else if (status.divisorZero) begin
          strobe.takeCurrent = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobe.divGo = 1'b1;
          stateNext = ST_DIVIDE;
        end
      end
      ST_DIVIDE: begin
        if (status.divLast) stateNext = ST_UPDATE;
      end
      ST_UPDATE: begin
        strobe.applyStep = 1'b1;
        stateNext = ST_CHECK;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign finish = strobe.unitResult | strobe.takeCurrent | strobe.takePrevious;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateR <= ST_IDLE;
      doneR  <= 1'b0;
    end else begin
      stateR <= stateNext;
      doneR  <= finish;
    end
  end

  assign engState = stateR;
  assign done     = doneR;

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    doneR |=> !doneR);

  // R6: the engine is idle whenever it reports completion
  assert_idle_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    doneR |-> (stateR == ST_IDLE));

  // R7: a start seen mid-search leaves the search running
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stateR == ST_DIVIDE && start && !status.divLast) |=> (stateR == ST_DIVIDE));

endmodule

// File: rtl/cfrac_approx.sv
module cfrac_approx import cfrac_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] givenNum,
  input  logic [WIDTH-1:0] givenDen,
  input  logic [WIDTH-1:0] maxNum,
  input  logic [WIDTH-1:0] maxDen,
  output logic             done,
  output logic [WIDTH-1:0] bestNum,
  output logic [WIDTH-1:0] bestDen
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  engState_t   engState;

  cfrac_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .status  (status),
    .strobe  (strobe),
    .engState(engState),
    .done    (done)
  );

  cfrac_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .givenNum(givenNum),
    .givenDen(givenDen),
    .maxNum  (maxNum),
    .maxDen  (maxDen),
    .status  (status),
    .bestNum (bestNum),
    .bestDen (bestDen)
  );

  // R2: an empty denominator gives 1/0 on the following cycle
  assert_zero_den_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (engState == ST_IDLE && start && givenDen == '0)
      |=> (done && bestNum == WIDTH'(1) && bestDen == '0));

  // R8: results move only together with the completion pulse
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(bestNum) && $stable(bestDen));

endmodule

// File: tb/cfrac_approx_bench.sv
`timescale 1ns/1ps
module cfrac_approx_bench;
  localparam int WIDTH = 32;
  localparam longint unsigned ALL1 = 64'hFFFF_FFFF;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] givenNum = '0, givenDen = '0, maxNum = '0, maxDen = '0;
  logic             done;
  logic [WIDTH-1:0] bestNum, bestDen;

  int    total = 0;
  int    bad = 0;
  string curTag = "R1";
  string holdTag = "R1";

  // model state
  logic            mDone = 1'b0;
  longint unsigned mNum = 0, mDen = 0, pendNum = 0, pendDen = 0;
  int              mCnt = 0;
  logic            mBusy = 1'b0;

  always #2 clk = ~clk;

  cfrac_approx #(.WIDTH(WIDTH)) u_cfrac_approx (
    .clk(clk), .rst_n(rst_n), .start(start),
    .givenNum(givenNum), .givenDen(givenDen), .maxNum(maxNum), .maxDen(maxDen),
    .done(done), .bestNum(bestNum), .bestDen(bestDen)
  );

  function automatic void refSolve(input longint unsigned gn, input longint unsigned gd,
                                   input longint unsigned mn, input longint unsigned md,
                                   output longint unsigned rn, output longint unsigned rd,
                                   output int steps);
    longint unsigned n = gn, d = gd, p0 = 0, p1 = 1, q0 = 1, q1 = 0, a, r, t;
    steps = 0;
    forever begin
      if (p1 > mn || q1 > md) begin rn = p0; rd = q0; return; end
      if (d == 0) begin rn = p1; rd = q1; return; end
      a = n / d; r = n % d; n = d; d = r;
      t = p0 + a * p1; if (t > ALL1) t = ALL1; p0 = p1; p1 = t;
      t = q0 + a * q1; if (t > ALL1) t = ALL1; q0 = q1; q1 = t;
      steps++;
    end
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mDone = 1'b0; mNum = 0; mDen = 0; mBusy = 1'b0; mCnt = 0;
    end else begin
      mDone = 1'b0;
      if (mBusy) begin
        mCnt--;
        if (mCnt == 0) begin
          mBusy = 1'b0; mDone = 1'b1; mNum = pendNum; mDen = pendDen;
        end
      end else if (start) begin
        if (givenDen == '0) begin
          mDone = 1'b1; mNum = 1; mDen = 0;
        end else begin
          int k;
          refSolve(givenNum, givenDen, maxNum, maxDen, pendNum, pendDen, k);
          mBusy = 1'b1;
          mCnt = 1 + k * (WIDTH + 2);
        end
      end
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    total++;
    if (done !== mDone) begin
      bad++;
      $display("FAIL R6: done got %0b exp %0b", done, mDone);
    end
    total++;
    if (bestNum !== 32'(mNum) || bestDen !== 32'(mDen)) begin
      bad++;
      $display("FAIL %s: result got %0d/%0d exp %0d/%0d",
               mDone ? curTag : holdTag, bestNum, bestDen, mNum, mDen);
    end
  end

  task automatic issue(input logic [WIDTH-1:0] n, input logic [WIDTH-1:0] d,
                       input logic [WIDTH-1:0] mn, input logic [WIDTH-1:0] md);
    @(negedge clk);
    givenNum = n; givenDen = d; maxNum = mn; maxDen = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runCase(input string tag, input logic [WIDTH-1:0] n, input logic [WIDTH-1:0] d,
                         input logic [WIDTH-1:0] mn, input logic [WIDTH-1:0] md);
    curTag = tag;
    issue(n, d, mn, md);
    while (mBusy || mDone) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    total++;
    if (done !== 1'b0 || bestNum !== '0 || bestDen !== '0) begin
      bad++;
      $display("FAIL R1: reset got done=%0b %0d/%0d exp 0 0/0", done, bestNum, bestDen);
    end
    holdTag = "R8";

    runCase("R2", 32'd5, 32'd0, 32'hFFFF, 32'hFFFF);
    runCase("R2", 32'd9, 32'd0, 32'd0, 32'd0);
    runCase("R4", 32'd3, 32'd4, 32'hFFFF, 32'hFFFF);
    runCase("R4", 32'd0, 32'd5, 32'hFFFF, 32'hFFFF);
    runCase("R4", 32'd7, 32'd7, 32'hFFFF, 32'hFFFF);
    runCase("R4", 32'd6, 32'd4, 32'hFFFF, 32'hFFFF);
    runCase("R3", 32'd314159265, 32'd100000000, 32'hFFFF, 32'hFFFF);
    runCase("R3", 32'd1000000, 32'd3, 32'hFFFF, 32'hFFFF);
    runCase("R3", 32'd1, 32'd2, 32'd0, 32'hFFFF);
    runCase("R3", 32'd100, 32'd1, 32'd50, 32'hFFFF);
    runCase("R3", 32'd355, 32'd113, 32'hFFFF, 32'd100);
    runCase("R5", 32'd2971215073, 32'd1836311903, 32'hFFFF, 32'hFFFF);
    runCase("R5", 32'd2971215073, 32'd1836311903, 32'hFFFF_FFF0, 32'hFFFF_FFF0);
    runCase("R9", 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runCase("R6", 32'd123456789, 32'd987654, 32'hFFFF, 32'hFFFF);

    // R7: second start mid-search must not disturb the first
    curTag = "R7";
    issue(32'd314159265, 32'd100000000, 32'hFFFF, 32'hFFFF);
    repeat (5) @(negedge clk);
    givenNum = 32'd1; givenDen = 32'd0; maxNum = 32'd3; maxDen = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: a start in the done cycle is accepted by an idle engine
    while (!mDone) @(negedge clk);
    givenNum = 32'd5; givenDen = 32'd8; maxNum = 32'hFFFF; maxDen = 32'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (mBusy || mDone) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6: watchdog expired, got no finish exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule